// File: doc/BRIEF.md
# Tagged Circular Register Stack

This block holds eight 80-bit floating-point registers in one file that can be used as a push-down stack or addressed relative to a 3-bit top-of-stack pointer. Each value has a sign in bit 79, a 15-bit exponent in bits 78..64 and a 64-bit significand in bits 63..0. Every register carries a 2-bit tag that says whether it is empty, holds zero, holds an ordinary value or holds a special value. The tag is worked out from the data each time the register is written.

A push moves the pointer down by one, with wrap-around, and writes the new top. A pop gives up the current top, moves the pointer up and marks the vacated register empty. Separate ports read and write a register chosen by an offset from the pointer, free a register, and load or read the whole tag word and the pointer. A push onto an occupied register is reported as a stack overflow. A pop or a read of an empty register is reported as an underflow. In both cases the faulting push or pop is suppressed.

Top module: `tagged_reg_stack`

## Requirements
- R1: After reset, and in the cycle after `init_i`, `top_o` is 0, `tag_word_o` is 16'hFFFF and `stk_fault_o`, `invalid_o` and `ovf_o` are 0. `init_i` overrides every other request in its cycle.
- R2: An accepted push moves `top_o` to (TOP-1) mod 8, so 0 wraps to 7, and stores `push_data_i` in that register. The register then reads back at offset 0.
- R3: While a pop is requested, `rd_data_o` at offset 0 shows the current top. An accepted pop moves `top_o` to (TOP+1) mod 8, so 7 wraps to 0, and tags the vacated register 11 (empty).
- R4: Read offset i, write offset i and free offset i all address physical register (TOP+i) mod 8. `rd_data_o` is combinational.
- R5: `tag_word_o` bits 2i+1..2i hold the tag of physical register i, whatever TOP is. The tag codes are 00 valid, 01 zero, 10 special and 11 empty.
- R6: A written value is tagged zero when exponent and significand are both all-zero. It is tagged special when the exponent is all ones, when the exponent is zero and the significand nonzero, or when the exponent is nonzero and bit 63 is clear. Otherwise it is tagged valid. The sign bit is ignored.
- R7: A push whose target register is not empty sets `stk_fault_o`, `invalid_o` and `ovf_o` to 1 in the next cycle. That push leaves TOP, the tags and the data unchanged.
- R8: A pop of an empty top, or a read (`rd_en_i`) of an empty register, sets `stk_fault_o` and `invalid_o` to 1 and `ovf_o` to 0 in the next cycle, and the pop is suppressed. If an overflow and an underflow occur in the same cycle, `ovf_o` is 1. The fault outputs are one-cycle pulses. `ovf_o` keeps its last direction until the next fault or init.
- R9: A free request tags register (TOP+`free_idx_i`) mod 8 empty and leaves TOP unchanged. When it hits the same register as a write, the free wins.
- R10: `top_ld_i` loads `top_i` and `tag_ld_i` loads `tag_word_i`. In a cycle with either load, push, pop, write, free and read faults are ignored.
- R11: When push and pop are requested together, the push is performed and the pop is ignored.
- R12: When a write and a pop fall in the same cycle, the write offset is taken from the old TOP and the pop still takes place. A written register that is also the vacated one ends up empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Initialise pointer and tags |
| push_i | input | 1 | Push request |
| push_data_i | input | 80 | Value to push |
| pop_i | input | 1 | Pop request |
| rd_en_i | input | 1 | Read request, checked for underflow |
| rd_idx_i | input | 3 | Top-relative read offset |
| rd_data_o | output | 80 | Read data |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 3 | Top-relative write offset |
| wr_data_i | input | 80 | Write data |
| free_i | input | 1 | Free request |
| free_idx_i | input | 3 | Top-relative free offset |
| tag_ld_i | input | 1 | Load tag word |
| tag_word_i | input | 16 | Tag word to load |
| tag_word_o | output | 16 | Packed tags by physical register |
| top_ld_i | input | 1 | Load pointer |
| top_i | input | 3 | Pointer to load |
| top_o | output | 3 | Current top-of-stack pointer |
| stk_fault_o | output | 1 | Stack fault pulse |
| invalid_o | output | 1 | Invalid-operation pulse |
| ovf_o | output | 1 | Fault direction: 1 overflow, 0 underflow |

## Verification
The pair that most easily collides is a top-relative write and a pop in the same cycle. Here the pointer moves while the write offset must still be resolved against the old pointer. The bench raises both together, once writing offset 1, so the written register becomes the new top, and once writing offset 0, so it hits the register being vacated. It judges the result from `top_o`, from `tag_word_o` (generated tag on one register, empty on the other) and from the offset-0 read data. Push together with pop, and an overflow together with a read underflow, are provoked the same way and judged from the pointer, the tags and the direction flag.

// File: rtl/tstk_pkg.sv
package tstk_pkg;
  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;
endpackage

// File: rtl/tstk_tag_gen.sv
module tstk_tag_gen
  import tstk_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W-1:0] mag_i,
  output tag_e                   tag_o
);
  logic [EXP_W-1:0] exp_w;
  logic [MAN_W-1:0] man_w;
  logic exp_zero, exp_ones, man_zero, int_bit;

  assign exp_w    = mag_i[EXP_W+MAN_W-1:MAN_W];
  assign man_w    = mag_i[MAN_W-1:0];
  assign exp_zero = (exp_w == '0);
  assign exp_ones = (exp_w == '1);
  assign man_zero = (man_w == '0);
  assign int_bit  = man_w[MAN_W-1];

  always_comb begin
    if (exp_zero && man_zero)                    tag_o = TAG_ZERO;
    else if (exp_ones)                           tag_o = TAG_SPECIAL;
    else if (exp_zero)                           tag_o = TAG_SPECIAL; // denormal
    else if (!int_bit)                           tag_o = TAG_SPECIAL; // unnormal
    else                                         tag_o = TAG_VALID;
  end
endmodule

// File: rtl/tstk_ptr.sv
module tstk_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ld_val_i,
  input  logic             dec_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] top_o
);
  logic [PTR_W-1:0] top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '0;
    else if (clr_i)  top_q <= '0;
    else if (ld_i)   top_q <= ld_val_i;
    else if (dec_i)  top_q <= top_q - 1'b1;
    else if (inc_i)  top_q <= top_q + 1'b1;
  end

  assign top_o = top_q;

  // R2: push moves pointer down with wrap
  a_r2_dec_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && dec_i) |=> (top_o == PTR_W'($past(top_o) - 1'b1)));

  // R3: pop moves pointer up with wrap
  a_r3_inc_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && !dec_i && inc_i) |=> (top_o == PTR_W'($past(top_o) + 1'b1)));
endmodule

// File: rtl/tstk_entry.sv
module tstk_entry
  import tstk_pkg::*;
#(
  parameter int W = 80
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_tag_i,
  input  logic         tag_ld_i,
  input  tag_e         tag_ld_val_i,
  input  logic         empty_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  tag_e         wr_tag_i,
  output logic [W-1:0] data_o,
  output tag_e         tag_o
);
  logic [W-1:0] data_q;
  tag_e         tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (wr_i) data_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tag_q <= TAG_EMPTY;
    else if (clr_tag_i) tag_q <= TAG_EMPTY;
    else if (tag_ld_i)  tag_q <= tag_ld_val_i;
    else if (empty_i)   tag_q <= TAG_EMPTY;
    else if (wr_i)      tag_q <= wr_tag_i;
  end

  assign data_o = data_q;
  assign tag_o  = tag_q;

  // R9/R12: vacate or free beats a same-cycle write
  a_r9_empty_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_i && !clr_tag_i && !tag_ld_i) |=> (tag_o == TAG_EMPTY));
endmodule

// File: rtl/tagged_reg_stack.sv
module tagged_reg_stack
  import tstk_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      init_i,
  input  logic                      push_i,
  input  logic [EXP_W+MAN_W:0]      push_data_i,
  input  logic                      pop_i,
  input  logic                      rd_en_i,
  input  logic [$clog2(NREG)-1:0]   rd_idx_i,
  output logic [EXP_W+MAN_W:0]      rd_data_o,
  input  logic                      wr_en_i,
  input  logic [$clog2(NREG)-1:0]   wr_idx_i,
  input  logic [EXP_W+MAN_W:0]      wr_data_i,
  input  logic                      free_i,
  input  logic [$clog2(NREG)-1:0]   free_idx_i,
  input  logic                      tag_ld_i,
  input  logic [2*NREG-1:0]         tag_word_i,
  output logic [2*NREG-1:0]         tag_word_o,
  input  logic                      top_ld_i,
  input  logic [$clog2(NREG)-1:0]   top_i,
  output logic [$clog2(NREG)-1:0]   top_o,
  output logic                      stk_fault_o,
  output logic                      invalid_o,
  output logic                      ovf_o
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int PTR_W = $clog2(NREG);

  logic [PTR_W-1:0] top_q, top_m1, rd_phys, wr_phys, fr_phys;
  logic [W-1:0]     regs [NREG];
  tag_e             tags [NREG];
  tag_e             push_tag, wr_tag;

  logic ops_en, push_req, pop_req;
  logic ovf_det, pop_unf, rd_unf, any_fault;
  logic push_ok, pop_ok, wr_ok, fr_ok;
  logic fault_q, ovf_q;

  // ---------------- pointer ----------------
  tstk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (init_i),
    .ld_i     (top_ld_i),
    .ld_val_i (top_i),
    .dec_i    (push_ok),
    .inc_i    (pop_ok),
    .top_o    (top_q)
  );

  assign top_m1  = top_q - 1'b1;
  assign rd_phys = top_q + rd_idx_i;
  assign wr_phys = top_q + wr_idx_i;
  assign fr_phys = top_q + free_idx_i;

  // ---------------- request arbitration ----------------
  assign ops_en   = !init_i && !tag_ld_i && !top_ld_i;
  assign push_req = ops_en && push_i;
  assign pop_req  = ops_en && pop_i && !push_i;     // push wins
  assign ovf_det  = push_req && (tags[top_m1] != TAG_EMPTY);
  assign pop_unf  = pop_req && (tags[top_q] == TAG_EMPTY);
  assign rd_unf   = ops_en && rd_en_i && (tags[rd_phys] == TAG_EMPTY);
  assign any_fault = ovf_det || pop_unf || rd_unf;

  assign push_ok = push_req && !ovf_det;
  assign pop_ok  = pop_req && !pop_unf;
  assign wr_ok   = ops_en && wr_en_i;
  assign fr_ok   = ops_en && free_i;

  // ---------------- tag generation ----------------
  tstk_tag_gen #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_push_tag (
    .mag_i (push_data_i[W-2:0]),
    .tag_o (push_tag)
  );

  tstk_tag_gen #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_wr_tag (
    .mag_i (wr_data_i[W-2:0]),
    .tag_o (wr_tag)
  );

  // ---------------- register file ----------------
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    localparam logic [PTR_W-1:0] IDX = PTR_W'(g);
    logic hit_push, hit_wr, hit_vac;

    assign hit_push = push_ok && (top_m1 == IDX);
    assign hit_wr   = wr_ok && (wr_phys == IDX);
    assign hit_vac  = (pop_ok && (top_q == IDX)) || (fr_ok && (fr_phys == IDX));

    tstk_entry #(.W(W)) u_ent (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_tag_i    (init_i),
      .tag_ld_i     (tag_ld_i),
      .tag_ld_val_i (tag_e'(tag_word_i[2*g +: 2])),
      .empty_i      (hit_vac),
      .wr_i         (hit_push || hit_wr),
      .wr_data_i    (hit_push ? push_data_i : wr_data_i),
      .wr_tag_i     (hit_push ? push_tag : wr_tag),
      .data_o       (regs[g]),
      .tag_o        (tags[g])
    );

    assign tag_word_o[2*g +: 2] = tags[g];
  end

  assign rd_data_o = regs[rd_phys];
  assign top_o     = top_q;

  // ---------------- fault reporting ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      fault_q <= any_fault;
      if (init_i)         ovf_q <= 1'b0;
      else if (any_fault) ovf_q <= ovf_det;
    end
  end

  assign stk_fault_o = fault_q;
  assign invalid_o   = fault_q;
  assign ovf_o       = ovf_q;

  // ---------------- assertions ----------------
  // R1
  a_r1_init_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (top_o == '0 && tag_word_o == '1 && !stk_fault_o && !ovf_o));

  // R7
  a_r7_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ops_en && push_i && tags[PTR_W'(top_o - 1'b1)] != TAG_EMPTY)
      |=> (stk_fault_o && invalid_o && ovf_o && top_o == $past(top_o)));

  // R8
  a_r8_pop_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ops_en && pop_i && !push_i && tags[top_o] == TAG_EMPTY)
      |=> (stk_fault_o && !ovf_o && top_o == $past(top_o)));

  // R10
  a_r10_load_blocks_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && top_ld_i) |=> (top_o == $past(top_i) && !stk_fault_o));
endmodule

// File: tb/tagged_reg_stack_test.sv
`timescale 1ns/1ps
module tagged_reg_stack_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        init, push, pop, rd_en, wr_en, fr, tag_ld, top_ld;
  logic [79:0] push_data, wr_data, rd_data;
  logic [2:0]  rd_idx, wr_idx, fr_idx, top_in, top;
  logic [15:0] tag_in, tag_word;
  logic        flt, inv, ovf;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tagged_reg_stack uut (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init),
    .push_i(push), .push_data_i(push_data), .pop_i(pop),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .free_i(fr), .free_idx_i(fr_idx),
    .tag_ld_i(tag_ld), .tag_word_i(tag_in), .tag_word_o(tag_word),
    .top_ld_i(top_ld), .top_i(top_in), .top_o(top),
    .stk_fault_o(flt), .invalid_o(inv), .ovf_o(ovf)
  );

  function automatic logic [79:0] dval(input logic [2:0] s);
    case (s)
      3'd0: dval = 80'h0;                                      // zero
      3'd1: dval = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};  // valid
      3'd2: dval = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};  // infinity
      3'd3: dval = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};  // denormal
      3'd4: dval = {1'b0, 15'h3FFF, 64'h4000_0000_0000_0000};  // unnormal
      3'd5: dval = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};  // negative valid
      3'd6: dval = {1'b0, 15'h4001, 64'hC000_0000_0000_0000};
      default: dval = {1'b0, 15'h4002, 64'hA000_0000_0000_0000};
    endcase
  endfunction

  typedef struct packed {
    logic        push, pop, wr, rd, fr;
    logic [2:0]  idx;
    logic [2:0]  dsel;
    logic [2:0]  top;
    logic [15:0] tags;
    logic        flt;
    logic        ovf;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd1,3'd7,16'h3FFF,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd0,3'd6,16'h1FFF,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd2,3'd5,16'h1BFF,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd3,3'd4,16'h1AFF,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd4,3'd3,16'h1ABF,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,3'd0,3'd4,16'h1AFF,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd1,3'd0,3'd4,16'h16FF,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,3'd4,3'd0,3'd4,16'h16FF,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd0,3'd4,16'h16FF,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd5,3'd3,16'h163F,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd6,3'd2,16'h160F,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd1,3'd1,16'h1603,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd5,3'd0,16'h1600,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd1,3'd0,16'h1600,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd0,3'd0,16'h1600,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,3'd0,3'd1,16'h1603,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,3'd0,3'd0,3'd1,16'h160F,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,3'd0,3'd1,16'h160F,1'b1,1'b0}
  };

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    init = 0; push = 0; pop = 0; rd_en = 0; wr_en = 0; fr = 0;
    tag_ld = 0; top_ld = 0;
    push_data = '0; wr_data = '0; tag_in = '0; top_in = '0;
    rd_idx = '0; wr_idx = '0; fr_idx = '0;
  endtask

  // inputs driven now are taken at the next rising edge; return at the following falling edge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic chk_state(input string req, input logic [2:0] et, input logic [15:0] ew,
                           input logic ef, input logic eo);
    chk({req, " top"}, 80'(top), 80'(et));
    chk({req, " tags"}, 80'(tag_word), 80'(ew));
    chk({req, " fault"}, 80'({flt, inv}), 80'({ef, ef}));
    chk({req, " ovf"}, 80'(ovf), 80'(eo));
  endtask

  task automatic rd_chk(input string req, input logic [2:0] i, input logic [79:0] exp);
    rd_idx = i;
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_state("R1 reset", 3'd0, 16'hFFFF, 1'b0, 1'b0);

    // vector table: R2 R3 R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      push = VECS[k].push; pop = VECS[k].pop; wr_en = VECS[k].wr;
      rd_en = VECS[k].rd; fr = VECS[k].fr;
      rd_idx = VECS[k].idx; wr_idx = VECS[k].idx; fr_idx = VECS[k].idx;
      push_data = dval(VECS[k].dsel); wr_data = dval(VECS[k].dsel);
      step();
      chk_state($sformatf("R2 R3 R5 R6 R7 R8 R9 vec%0d", k),
                VECS[k].top, VECS[k].tags, VECS[k].flt, VECS[k].ovf);
    end

    // R1: init beats a push in the same cycle
    init = 1; push = 1; push_data = dval(1);
    step();
    chk_state("R1 init", 3'd0, 16'hFFFF, 1'b0, 1'b0);

    // R2 wrap 0->7, R3 pop data and wrap 7->0
    push = 1; push_data = dval(5);
    step();
    chk_state("R2 wrap push", 3'd7, 16'h3FFF, 1'b0, 1'b0);
    pop = 1;
    rd_chk("R3 pop data", 3'd0, dval(5));
    step();
    chk_state("R3 wrap pop", 3'd0, 16'hFFFF, 1'b0, 1'b0);

    // R4 top-relative addressing
    push = 1; push_data = dval(1); step();
    push = 1; push_data = dval(7); step();
    chk_state("R4 setup", 3'd6, 16'h0FFF, 1'b0, 1'b0);
    rd_chk("R4 offset1", 3'd1, dval(1));
    rd_chk("R4 offset0", 3'd0, dval(7));

    // R10 pointer load ignores a same-cycle push
    top_ld = 1; top_in = 3'd5; push = 1; push_data = dval(3);
    step();
    chk_state("R10 top load", 3'd5, 16'h0FFF, 1'b0, 1'b0);
    rd_chk("R4 offset2 at top5", 3'd2, dval(1));
    top_ld = 1; top_in = 3'd7; step();
    rd_chk("R4 offset7 wraps", 3'd7, dval(7));
    top_ld = 1; top_in = 3'd6; step();
    chk_state("R10 top reload", 3'd6, 16'h0FFF, 1'b0, 1'b0);

    // R12 write offset1 + pop: written register becomes new top
    wr_en = 1; wr_idx = 3'd1; wr_data = dval(0); pop = 1;
    step();
    chk_state("R12 write+pop", 3'd7, 16'h7FFF, 1'b0, 1'b0);
    rd_chk("R12 new top data", 3'd0, dval(0));

    // R11 push + pop: push wins
    push = 1; push_data = dval(2); pop = 1;
    step();
    chk_state("R11 push+pop", 3'd6, 16'h6FFF, 1'b0, 1'b0);
    rd_chk("R11 top data", 3'd0, dval(2));

    // R12 write offset0 + pop: vacated register stays empty
    wr_en = 1; wr_idx = 3'd0; wr_data = dval(5); pop = 1;
    step();
    chk_state("R12 write same as vacated", 3'd7, 16'h7FFF, 1'b0, 1'b0);

    // R10 tag load ignores push
    tag_ld = 1; tag_in = 16'h0000; push = 1; push_data = dval(1);
    step();
    chk_state("R10 tag load", 3'd7, 16'h0000, 1'b0, 1'b0);

    // R8 precedence: overflow and read underflow together
    tag_ld = 1; tag_in = 16'h000C; step();
    push = 1; push_data = dval(1); rd_en = 1; rd_idx = 3'd2;
    step();
    chk_state("R8 ovf precedence", 3'd7, 16'h000C, 1'b1, 1'b1);

    // R8 read underflow alone, then pulse ends
    rd_en = 1; rd_idx = 3'd2;
    step();
    chk_state("R8 read underflow", 3'd7, 16'h000C, 1'b1, 1'b0);
    step();
    chk_state("R8 pulse ends", 3'd7, 16'h000C, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule